// File: doc/BRIEF.md
# Host Bridge Configuration Header Register File

This block holds a handful of configuration-space header registers for a host bridge function and answers dword-wide reads and byte-enabled writes on them. It serves the function-identity byte, the self-test byte, the graphics aperture base, the two subsystem identity fields and the capability list pointer. Transaction decoding happens upstream: the block sees a write strobe with a dword index, byte enables and data, plus a read dword index whose data is returned combinationally.

The aperture base stores its upper address bits. On every read those bits pass through a mask built from an external aperture-size vector, so a cleared size bit makes the matching base bit read as 0. A mode input chooses between a legacy layout, where eight size bits gate base bits 27:20, and an extended layout, where size bits 11:8 gate base bits 31:28 and size bits 5:0 gate base bits 27:22. The two subsystem identity fields take exactly one write each after reset and are read-only from then on.

Top module: `bridge_cfg_hdr`

## Requirements
- R1: After reset, the aperture base (dword index 4) reads 0x00000008 and the identity dword (index 11) reads 0x00000000.
- R2: In the aperture base, bit 3 always reads 1, bits 2:0 read 0, and bits 19:4 read 0 in the legacy layout and bits 21:4 in the extended layout.
- R3: With ap_mode = 0, base bits 31:28 read back what was stored, and base bit 20+k (k = 0..7) reads the stored bit only while ap_size[k] = 1, otherwise 0.
- R4: With ap_mode = 1, base bit 28+k (k = 0..3) is gated by ap_size[8+k], base bit 22+k (k = 0..5) by ap_size[k]; ap_size[7:6] gate nothing.
- R5: Masking happens on read only: a write with wr_be[3] stores data bits 31:24 and with wr_be[2] stores bits 23:20, whatever the size and mode; a masked stored bit reads 0 and reappears when its size bit returns to 1.
- R6: Dword 11 holds the subsystem vendor field in bits 15:0 and the subsystem field in bits 31:16, both reset to 0. The first write whose byte enables touch a field stores its enabled bytes and locks that field; later writes leave it unchanged until reset. Each field locks on its own.
- R7: Dword index 3 reads 0x00800000 when multi_fn = 1 and 0x00000000 when multi_fn = 0 (identity byte in bits 23:16, self-test byte in bits 31:24 always 0).
- R8: Dword index 13 always reads 0x00000080, and writes to it have no effect.
- R9: Reads of any other dword index return 0, and writes to them change no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_dw | input | 6 | Dword index of the write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_dw | input | 6 | Dword index of the read |
| rd_data | output | 32 | Read data, combinational from rd_dw and state |
| ap_size | input | 12 | Aperture size vector gating base bits |
| ap_mode | input | 1 | Base layout: 0 legacy, 1 extended |
| multi_fn | input | 1 | Function-identity control |

## Verification
A size or mode change and a read of the aperture base can land in the same cycle as a write to it, so the read must reflect the new mask against the old stored bits, and the next cycle the new stored bits. The bench drives random size, mode, write and read streams together, sometimes writing and reading dword 4 at once while the size flips, and compares every cycle's read against a behavioural model that keeps stored bits and applies masks from R3 and R4 afresh. The same holds for a first write to a subsystem field landing in the cycle it is read: the read shows the old value and the next cycle the locked new one.

// File: rtl/bridge_cfg_pkg.sv
package bridge_cfg_pkg;
   localparam int HDR_DW = 3;
   localparam int APB_DW = 4;
   localparam int SID_DW = 11;
   localparam int CAP_DW = 13;
   localparam logic [31:0] CAP_VALUE = 32'h0000_0080;
   localparam logic [7:0] MULTI_FN_CODE = 8'h80;
   localparam logic [3:0] APB_LOW_NIBBLE = 4'h8;
endpackage

// File: rtl/cfg_apbase.sv
module cfg_apbase #(
   parameter int SIZE_W = 12,
   parameter bit EXT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [1:0]        be,
   input  logic [11:0]       d,
   input  logic [SIZE_W-1:0] size,
   input  logic              mode,
   output logic [31:0]       q
);
   import bridge_cfg_pkg::*;

   localparam int STW = 12;

   if (SIZE_W != 12) begin : g_bad_size
      $error("cfg_apbase: SIZE_W must be 12");
   end

   logic [STW-1:0] stor;
   logic [STW-1:0] leg_mask;
   logic [STW-1:0] ext_mask;
   logic [STW-1:0] eff_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stor <= '0;
      end else if (wr) begin
         if (be[1]) stor[11:4] <= d[11:4];
         if (be[0]) stor[3:0]  <= d[3:0];
      end
   end

   for (genvar k = 0; k < 8; k++) begin : g_leg
      assign leg_mask[k] = size[k];
   end
   assign leg_mask[11:8] = 4'hF;

   assign ext_mask[1:0] = 2'b00;
   for (genvar k = 0; k < 6; k++) begin : g_ext_lo
      assign ext_mask[k+2] = size[k];
   end
   for (genvar k = 0; k < 4; k++) begin : g_ext_hi
      assign ext_mask[k+8] = size[k+8];
   end

   if (EXT_EN) begin : g_two_layouts
      assign eff_mask = mode ? ext_mask : leg_mask;
   end else begin : g_legacy_only
      logic unused_mode;
      assign unused_mode = mode ^ (|ext_mask);
      assign eff_mask = leg_mask;
   end

   assign q = {stor & eff_mask, 16'h0000, APB_LOW_NIBBLE};

   a_r3_legacy_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !mode |-> ((q[27:20] & ~size[7:0]) == 8'h00));

   a_r4_ext_gate: assert property (@(posedge clk) disable iff (!rst_n)
      mode |-> (((q[31:28] & ~size[11:8]) == 4'h0) && ((q[27:22] & ~size[5:0]) == 6'h00)
                && (q[21:20] == 2'b00)));

   a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(stor));
endmodule

// File: rtl/cfg_wonce.sv
module cfg_wonce #(
   parameter int W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic [W/8-1:0] be,
   input  logic [W-1:0]   d,
   output logic [W-1:0]   q
);
   localparam int NB = W / 8;

   if (W % 8 != 0 || W == 0) begin : g_bad_w
      $error("cfg_wonce: W must be a nonzero multiple of 8");
   end

   logic locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
      end else if (wr) begin
         locked <= 1'b1;
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[b*8 +: 8] <= '0;
         end else if (wr && !locked && be[b]) begin
            q[b*8 +: 8] <= d[b*8 +: 8];
         end
      end
   end

   a_r6_frozen_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(q));

   a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux #(
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] rd_dw,
   input  logic              multi_fn,
   input  logic [31:0]       apb_q,
   input  logic [15:0]       svid_q,
   input  logic [15:0]       sid_q,
   output logic [31:0]       rd_data
);
   import bridge_cfg_pkg::*;

   always_comb begin
      rd_data = '0;
      unique case (rd_dw)
         ADDR_W'(HDR_DW): rd_data = {8'h00, (multi_fn ? MULTI_FN_CODE : 8'h00), 16'h0000};
         ADDR_W'(APB_DW): rd_data = apb_q;
         ADDR_W'(SID_DW): rd_data = {sid_q, svid_q};
         ADDR_W'(CAP_DW): rd_data = CAP_VALUE;
         default:         rd_data = '0;
      endcase
   end
endmodule

// File: rtl/bridge_cfg_hdr.sv
module bridge_cfg_hdr #(
   parameter int ADDR_W = 6,
   parameter int SIZE_W = 12,
   parameter bit EXT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_dw,
   input  logic [3:0]        wr_be,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_dw,
   output logic [31:0]       rd_data,
   input  logic [SIZE_W-1:0] ap_size,
   input  logic              ap_mode,
   input  logic              multi_fn
);
   import bridge_cfg_pkg::*;

   localparam int NDW = 1 << ADDR_W;

   if (ADDR_W < 4 || NDW <= CAP_DW) begin : g_bad_addr
      $error("bridge_cfg_hdr: ADDR_W too small for the header dwords");
   end

   logic        apb_wr;
   logic        svid_wr;
   logic        sid_wr;
   logic [31:0] apb_q;
   logic [15:0] svid_q;
   logic [15:0] sid_q;
   logic        unused_wr_bits;

   assign apb_wr  = wr_en && (wr_dw == ADDR_W'(APB_DW)) && (wr_be[3] || wr_be[2]);
   assign svid_wr = wr_en && (wr_dw == ADDR_W'(SID_DW)) && (|wr_be[1:0]);
   assign sid_wr  = wr_en && (wr_dw == ADDR_W'(SID_DW)) && (|wr_be[3:2]);
   assign unused_wr_bits = ^wr_data[19:0];

   cfg_apbase #(.SIZE_W(SIZE_W), .EXT_EN(EXT_EN)) u_apb (
      .clk(clk), .rst_n(rst_n), .wr(apb_wr), .be(wr_be[3:2]), .d(wr_data[31:20]),
      .size(ap_size), .mode(ap_mode), .q(apb_q)
   );

   cfg_wonce #(.W(16)) u_svid (
      .clk(clk), .rst_n(rst_n), .wr(svid_wr), .be(wr_be[1:0]), .d(wr_data[15:0]), .q(svid_q)
   );

   cfg_wonce #(.W(16)) u_sid (
      .clk(clk), .rst_n(rst_n), .wr(sid_wr), .be(wr_be[3:2]), .d(wr_data[31:16]), .q(sid_q)
   );

   cfg_rd_mux #(.ADDR_W(ADDR_W)) u_mux (
      .rd_dw(rd_dw), .multi_fn(multi_fn), .apb_q(apb_q), .svid_q(svid_q), .sid_q(sid_q),
      .rd_data(rd_data)
   );

   a_r8_cap_const: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dw == ADDR_W'(CAP_DW)) |-> (rd_data == 32'h0000_0080));

   a_r2_apb_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dw == ADDR_W'(APB_DW)) |-> (rd_data[19:0] == 20'h00008));

   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dw != ADDR_W'(HDR_DW) && rd_dw != ADDR_W'(APB_DW) && rd_dw != ADDR_W'(SID_DW)
       && rd_dw != ADDR_W'(CAP_DW)) |-> (rd_data == 32'h0));
endmodule

// File: tb/bridge_cfg_hdr_test.sv
module bridge_cfg_hdr_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_dw = '0;
   logic [3:0]  wr_be = '0;
   logic [31:0] wr_data = '0;
   logic [5:0]  rd_dw = '0;
   logic [31:0] rd_data;
   logic [11:0] ap_size = '0;
   logic        ap_mode = 1'b0;
   logic        multi_fn = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [11:0] m_stor = '0;
   logic [15:0] m_svid = '0;
   logic [15:0] m_sid = '0;
   bit          m_svid_lk = 1'b0;
   bit          m_sid_lk = 1'b0;

   always #10 clk = ~clk;

   bridge_cfg_hdr uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dw(wr_dw), .wr_be(wr_be),
      .wr_data(wr_data), .rd_dw(rd_dw), .rd_data(rd_data), .ap_size(ap_size),
      .ap_mode(ap_mode), .multi_fn(multi_fn)
   );

   function automatic logic [31:0] model_rd(input logic [5:0] a, input logic [11:0] sz,
                                            input logic md, input logic mf);
      logic [31:0] base;
      logic [31:0] msk;
      msk = '0;
      if (!md) begin
         msk[31:28] = 4'hF;
         for (int k = 0; k < 8; k++) msk[20+k] = sz[k];
      end else begin
         for (int k = 0; k < 4; k++) msk[28+k] = sz[8+k];
         for (int k = 0; k < 6; k++) msk[22+k] = sz[k];
      end
      base = {m_stor, 20'h0} & msk;
      base[3] = 1'b1;
      case (a)
         6'd3:    return mf ? 32'h0080_0000 : 32'h0;
         6'd4:    return base;
         6'd11:   return {m_sid, m_svid};
         6'd13:   return 32'h0000_0080;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [5:0] a, input logic md);
      case (a)
         6'd3:    return "R7";
         6'd4:    return md ? "R4" : "R3";
         6'd11:   return "R6";
         6'd13:   return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string tag);
      logic [31:0] e;
      e = model_rd(rd_dw, ap_size, ap_mode, multi_fn);
      n_chk++;
      if (rd_data !== e) begin
         n_bad++;
         $display("FAIL %s: dw=%0d actual=%08h expected=%08h", tag, rd_dw, rd_data, e);
      end
   endtask

   task automatic model_write();
      if (!wr_en) return;
      if (wr_dw == 6'd4) begin
         if (wr_be[3]) m_stor[11:4] = wr_data[31:24];
         if (wr_be[2]) m_stor[3:0]  = wr_data[23:20];
      end
      if (wr_dw == 6'd11) begin
         if ((|wr_be[1:0]) && !m_svid_lk) begin
            if (wr_be[0]) m_svid[7:0]  = wr_data[7:0];
            if (wr_be[1]) m_svid[15:8] = wr_data[15:8];
            m_svid_lk = 1'b1;
         end
         if ((|wr_be[3:2]) && !m_sid_lk) begin
            if (wr_be[2]) m_sid[7:0]  = wr_data[23:16];
            if (wr_be[3]) m_sid[15:8] = wr_data[31:24];
            m_sid_lk = 1'b1;
         end
      end
   endtask

   // one cycle: drive at negedge, compare after settling, then model the edge
   task automatic cyc(input logic we, input logic [5:0] wa, input logic [3:0] be,
                      input logic [31:0] wd, input logic [5:0] ra, input logic [11:0] sz,
                      input logic md, input logic mf, input string tag);
      wr_en = we; wr_dw = wa; wr_be = be; wr_data = wd;
      rd_dw = ra; ap_size = sz; ap_mode = md; multi_fn = mf;
      #1;
      check(tag == "" ? tag_of(ra, md) : tag);
      @(posedge clk);
      model_write();
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [5:0] pick [6];
      pick[0] = 6'd3; pick[1] = 6'd4; pick[2] = 6'd11; pick[3] = 6'd13;
      pick[4] = 6'd0; pick[5] = 6'd4;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values
      cyc(0, 0, 0, 0, 6'd4, 12'hFFF, 0, 0, "R1");
      cyc(0, 0, 0, 0, 6'd11, 12'hFFF, 0, 0, "R1");
      // R2 fixed low bits after an all-ones write
      cyc(1, 6'd4, 4'hF, 32'hFFFF_FFFF, 6'd4, 12'hFFF, 0, 0, "R2");
      cyc(0, 0, 0, 0, 6'd4, 12'hFFF, 0, 0, "R2");
      cyc(0, 0, 0, 0, 6'd4, 12'hFFF, 1, 0, "R2");
      // R3 legacy gating, R4 extended gating, R5 retention
      cyc(0, 0, 0, 0, 6'd4, 12'h000, 0, 0, "R3");
      cyc(0, 0, 0, 0, 6'd4, 12'h0A5, 0, 0, "R3");
      cyc(0, 0, 0, 0, 6'd4, 12'h000, 1, 0, "R4");
      cyc(0, 0, 0, 0, 6'd4, 12'h5C3, 1, 0, "R4");
      cyc(1, 6'd4, 4'h4, 32'h0000_0000, 6'd4, 12'h000, 0, 0, "R5");
      cyc(0, 0, 0, 0, 6'd4, 12'hFFF, 0, 0, "R5");
      cyc(1, 6'd4, 4'h8, 32'h5A00_0000, 6'd4, 12'hFFF, 0, 0, "R5");
      cyc(0, 0, 0, 0, 6'd4, 12'hFFF, 1, 0, "R5");
      // R6 write once, per field
      cyc(1, 6'd11, 4'h1, 32'hFFFF_1234, 6'd11, 0, 0, 0, "R6");
      cyc(1, 6'd11, 4'h3, 32'hFFFF_9999, 6'd11, 0, 0, 0, "R6");
      cyc(1, 6'd11, 4'hC, 32'hBEEF_0000, 6'd11, 0, 0, 0, "R6");
      cyc(1, 6'd11, 4'hF, 32'h1111_1111, 6'd11, 0, 0, 0, "R6");
      cyc(0, 0, 0, 0, 6'd11, 0, 0, 0, "R6");
      // R7 identity byte, R8 capability pointer, R9 unmapped
      cyc(0, 0, 0, 0, 6'd3, 0, 0, 1, "R7");
      cyc(1, 6'd3, 4'hF, 32'hFFFF_FFFF, 6'd3, 0, 0, 0, "R7");
      cyc(1, 6'd13, 4'hF, 32'hFFFF_FFFF, 6'd13, 0, 0, 0, "R8");
      cyc(1, 6'd20, 4'hF, 32'hFFFF_FFFF, 6'd20, 0, 0, 0, "R9");
      cyc(0, 0, 0, 0, 6'd63, 0, 0, 0, "R9");
      // random traffic with aperture writes, size flips and reads colliding
      for (int i = 0; i < 4000; i++) begin
         logic [5:0] wa;
         logic [5:0] ra;
         wa = ($urandom_range(0, 3) == 0) ? 6'($urandom) : pick[$urandom_range(0, 5)];
         ra = ($urandom_range(0, 4) == 0) ? 6'($urandom) : pick[$urandom_range(0, 5)];
         if (i == 2000) begin
            rst_n = 1'b0;
            #1;
            m_stor = '0; m_svid = '0; m_sid = '0; m_svid_lk = 1'b0; m_sid_lk = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
         end
         cyc(($urandom_range(0, 2) == 0), wa, 4'($urandom), $urandom, ra,
             12'($urandom), 1'($urandom), 1'($urandom), "");
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule